// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This unit sits after the execute stage and talks to a word-wide data memory that has one write enable per byte. Every request carries an operation, a base register value, a signed 16-bit displacement and, for stores, the source register. The unit adds the sign-extended displacement to the base to form the byte address. It presents the word-aligned address to memory and works out which byte lane is involved. The lane depends on the low address bits and on the endianness chosen for that request. Word stores and word loads move the whole word. A byte store puts the low source byte on the selected lane and enables only that lane. A byte load takes the selected lane from the returned word and sign-extends it.

Memory reads take one clock. A small state machine has two states. `ST_IDLE` accepts requests. `ST_LOAD_WAIT` is the single cycle in which the read word comes back and the load result is formed. There are three transitions:
- *accept_load* goes from `ST_IDLE` to `ST_LOAD_WAIT` on an aligned load.
- *return* goes from `ST_LOAD_WAIT` to `ST_IDLE` unconditionally.
- *hold* keeps `ST_IDLE` for stores, misaligned requests and idle cycles.

A word access whose address is not a multiple of four raises a misalignment flag and never reaches memory.

Top module: `lsu_byte_lane`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` equals that address with bits [1:0] cleared, in the same cycle as the request.
- R2: An aligned word store (`req_op`=2'b10) asserts `mem_wr_en` in the request cycle, with `mem_be`=4'b1111 and `mem_wdata`=`req_wdata` unchanged.
- R3: A byte store (`req_op`=2'b11) asserts `mem_wr_en` with a one-hot `mem_be` at lane L. Lane L is addr[1:0] when `big_endian`=0 and 3-addr[1:0] when `big_endian`=1. Lane L of `mem_wdata` (bits 8L+7..8L) carries `req_wdata[7:0]`.
- R4: An aligned word load (`req_op`=2'b00) asserts `mem_rd_en` in the request cycle. In the next cycle `ld_valid` is 1 and `ld_data` equals the word memory returned.
- R5: A byte load (`req_op`=2'b01) gives lane L of the returned word (L as in R3) in `ld_data[7:0]`, with bits 31..8 copies of that byte's bit 7.
- R6: A word load or store with addr[1:0]≠0 asserts `misalign` in the request cycle and asserts neither `mem_rd_en` nor `mem_wr_en`. No load result follows, and memory is left unchanged.
- R7: Byte loads and stores never assert `misalign`, whatever the address.
- R8: In `ST_LOAD_WAIT` the unit asserts `busy`. A request presented in that cycle is ignored: it drives no memory strobe and alters no memory.
- R9: While `rst_n` is low the unit returns to `ST_IDLE` at once. `busy`, `ld_valid`, `mem_rd_en` and `mem_wr_en` are all 0.
- R10: The lane of a byte load is fixed by `big_endian` in the request cycle. A change of `big_endian` during `ST_LOAD_WAIT` does not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 word load, 01 byte load, 10 word store, 11 byte store |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| big_endian | input | 1 | 1: byte 0 in bits 31..24; 0: byte 0 in bits 7..0 |
| busy | output | 1 | Load result pending; requests ignored |
| misalign | output | 1 | Word access at a non-multiple-of-4 address |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after `mem_rd_en` |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |

## Verification
Address, misalignment flag, byte enables, write data and read strobe are combinational from the request. They are due in the request cycle itself. The bench drives each request just after a falling edge and samples these outputs one nanosecond later. The load result passes through one memory register and one state register, so it is due one clock later. The bench samples it after the following falling edge, once the request has been withdrawn. Store effects are checked through later loads that compare against a bench-side shadow memory.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

    typedef enum logic [1:0] {
        OP_LW = 2'b00,
        OP_LB = 2'b01,
        OP_SW = 2'b10,
        OP_SB = 2'b11
    } lsu_op_e;

    typedef enum logic {
        ST_IDLE      = 1'b0,
        ST_LOAD_WAIT = 1'b1
    } lsu_state_e;

endpackage

// File: rtl/lsu_agen.sv
`timescale 1ns/1ps
module lsu_agen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              is_word,
    output logic [ADDR_W-1:0] word_addr,
    output logic [IDX_W-1:0]  byte_off,
    output logic              misalign
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ea;

    always_comb begin
        ea        = base + {{EXT_W{offset[OFF_W-1]}}, offset};
        byte_off  = ea[IDX_W-1:0];
        word_addr = {ea[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
        misalign  = is_word && (byte_off != '0);
    end
endmodule

// File: rtl/lsu_lane_sel.sv
`timescale 1ns/1ps
module lsu_lane_sel #(
    parameter int LANES = 4,
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] byte_off,
    input  logic             big_endian,
    output logic [IDX_W-1:0] lane_idx,
    output logic [LANES-1:0] lane_onehot
);
    localparam logic [IDX_W-1:0] TOP_LANE = IDX_W'(LANES - 1);

    always_comb begin
        lane_idx = big_endian ? (TOP_LANE - byte_off) : byte_off;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_onehot
        assign lane_onehot[g] = (lane_idx == IDX_W'(g));
    end
endmodule

// File: rtl/lsu_store_fmt.sv
`timescale 1ns/1ps
module lsu_store_fmt #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              is_byte,
    input  logic [LANES-1:0]  lane_onehot,
    input  logic [DATA_W-1:0] src_data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    always_comb begin
        be = is_byte ? lane_onehot : {LANES{1'b1}};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wdata[g*8 +: 8] = is_byte ? src_data[7:0] : src_data[g*8 +: 8];
    end
endmodule

// File: rtl/lsu_load_fmt.sv
`timescale 1ns/1ps
module lsu_load_fmt #(
    parameter int DATA_W = 32,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic              is_byte,
    input  logic [IDX_W-1:0]  lane_idx,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0] lanes [LANES];
    logic [7:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lanes[g] = rdata[g*8 +: 8];
    end

    always_comb begin
        picked = lanes[lane_idx];
        result = is_byte ? {{(DATA_W-8){picked[7]}}, picked} : rdata;
    end
endmodule

// File: rtl/lsu_byte_lane.sv
`timescale 1ns/1ps
module lsu_byte_lane
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [DATA_W-1:0]     req_base,
    input  logic [OFF_W-1:0]      req_offset,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic                  big_endian,
    output logic                  busy,
    output logic                  misalign,
    output logic [DATA_W-1:0]     mem_addr,
    output logic                  mem_rd_en,
    output logic                  mem_wr_en,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  ld_valid,
    output logic [DATA_W-1:0]     ld_data
);
    localparam int LANES = DATA_W / 8;
    localparam int IDX_W = $clog2(LANES);

    lsu_state_e state_q, state_d;

    logic              op_store, op_byte;
    logic [IDX_W-1:0]  byte_off, lane_idx, lane_q;
    logic [LANES-1:0]  lane_onehot, fmt_be;
    logic [DATA_W-1:0] fmt_wdata, fmt_result, word_addr;
    logic              addr_bad, byte_q;

    always_comb begin
        op_store = req_op[1];
        op_byte  = req_op[0];
    end

    lsu_agen #(.ADDR_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_agen (
        .base      (req_base),
        .offset    (req_offset),
        .is_word   (!op_byte),
        .word_addr (word_addr),
        .byte_off  (byte_off),
        .misalign  (addr_bad)
    );

    lsu_lane_sel #(.LANES(LANES), .IDX_W(IDX_W)) u_lane (
        .byte_off    (byte_off),
        .big_endian  (big_endian),
        .lane_idx    (lane_idx),
        .lane_onehot (lane_onehot)
    );

    lsu_store_fmt #(.DATA_W(DATA_W), .LANES(LANES)) u_st (
        .is_byte     (op_byte),
        .lane_onehot (lane_onehot),
        .src_data    (req_wdata),
        .be          (fmt_be),
        .wdata       (fmt_wdata)
    );

    lsu_load_fmt #(.DATA_W(DATA_W), .LANES(LANES), .IDX_W(IDX_W)) u_ld (
        .is_byte  (byte_q),
        .lane_idx (lane_q),
        .rdata    (mem_rdata),
        .result   (fmt_result)
    );

    // State register plus the load context captured on accept_load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            byte_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_LOAD_WAIT) begin
                lane_q <= lane_idx;
                byte_q <= op_byte;
            end
        end
    end

    // Transitions: accept_load, return, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !op_store && !addr_bad) state_d = ST_LOAD_WAIT;
            end
            ST_LOAD_WAIT: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        misalign  = 1'b0;
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_be    = '0;
        ld_valid  = 1'b0;
        ld_data   = '0;
        mem_addr  = word_addr;
        mem_wdata = fmt_wdata;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    misalign = addr_bad;
                    if (!addr_bad) begin
                        if (op_store) begin
                            mem_wr_en = 1'b1;
                            mem_be    = fmt_be;
                        end else begin
                            mem_rd_en = 1'b1;
                        end
                    end
                end
            end
            ST_LOAD_WAIT: begin
                busy     = 1'b1;
                ld_valid = 1'b1;
                ld_data  = fmt_result;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsu_byte_lane_chk.sv
`timescale 1ns/1ps
module lsu_byte_lane_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                misalign,
    input logic [DATA_W-1:0]   mem_addr,
    input logic                mem_rd_en,
    input logic                mem_wr_en,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                ld_valid
);
    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || mem_wr_en) |-> (mem_addr[1:0] == 2'b00)); // R1

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_be) == 1 || mem_be == '1)); // R3

    AST_READ_THEN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ld_valid); // R4

    AST_RESULT_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(mem_rd_en)); // R4

    AST_MISALIGN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_rd_en && !mem_wr_en)); // R6

    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mem_rd_en && !mem_wr_en && !misalign)); // R8

    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> !ld_valid); // R8
endmodule

bind lsu_byte_lane lsu_byte_lane_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .misalign  (misalign),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_be    (mem_be),
    .ld_valid  (ld_valid)
);

// File: tb/test_lsu_byte_lane.sv
`timescale 1ns/1ps
module test_lsu_byte_lane;
    import lsu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        big_endian = 1'b0;
    logic        busy, misalign, mem_rd_en, mem_wr_en, ld_valid;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] mem    [16];
    logic [31:0] shadow [16];

    always #4 clk = ~clk;

    lsu_byte_lane i_lsu_byte_lane (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .big_endian(big_endian), .busy(busy), .misalign(misalign),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    // Memory model: one-cycle read, byte-enabled write
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[5:2]];
        if (mem_wr_en)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end

    typedef struct packed {
        logic [1:0]  op;
        logic        big;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] wdata;
        logic        mis;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{OP_SW, 1'b0, 32'h0000_0020, 16'h0000, 32'h1122_3344, 1'b0},
        '{OP_LW, 1'b0, 32'h0000_0024, 16'hFFFC, 32'h0,         1'b0},
        '{OP_SB, 1'b0, 32'h0000_0030, 16'h0001, 32'hAAAA_AA85, 1'b0},
        '{OP_LB, 1'b0, 32'h0000_0031, 16'h0000, 32'h0,         1'b0},
        '{OP_SB, 1'b1, 32'h0000_0040, 16'h0002, 32'h0000_007F, 1'b0},
        '{OP_LB, 1'b1, 32'h0000_0042, 16'h0000, 32'h0,         1'b0},
        '{OP_LB, 1'b1, 32'h0000_0040, 16'h0003, 32'h0,         1'b0},
        '{OP_SW, 1'b0, 32'h0000_0022, 16'h0000, 32'hCAFE_F00D, 1'b1},
        '{OP_LW, 1'b0, 32'h0000_0020, 16'h0001, 32'h0,         1'b1},
        '{OP_LW, 1'b0, 32'h0000_0020, 16'h0000, 32'h0,         1'b0},
        '{OP_LB, 1'b0, 32'h0001_0003, 16'h8000, 32'h0,         1'b0},
        '{OP_SB, 1'b1, 32'h0000_0008, 16'h0000, 32'hDEAD_BEEF, 1'b0},
        '{OP_LW, 1'b1, 32'h0000_0008, 16'h0000, 32'h0,         1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ea_of(input logic [31:0] b, input logic [15:0] o);
        return b + {{16{o[15]}}, o};
    endfunction

    function automatic int lane_of(input logic [1:0] lo, input logic big);
        return big ? 3 - int'(lo) : int'(lo);
    endfunction

    // One request through the unit; request-cycle checks, then result-cycle checks
    task automatic do_req(input logic [1:0] op, input logic big, input logic [31:0] base,
                          input logic [15:0] off, input logic [31:0] wd, input logic mis);
        logic [31:0] ea, word, exp_ld;
        int ln;
        ea = ea_of(base, off);
        ln = lane_of(ea[1:0], big);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
        req_wdata = wd; big_endian = big;
        #1;
        chk(mem_addr == {ea[31:2], 2'b00}, "R1 addr", mem_addr, {ea[31:2], 2'b00});
        chk(misalign == mis, mis ? "R6 misalign" : "R7 misalign", 32'(misalign), 32'(mis));
        if (mis) begin
            chk(!mem_wr_en && !mem_rd_en, "R6 strobes", {mem_wr_en, mem_rd_en}, 0);
        end else if (op == OP_SW) begin
            chk(mem_wr_en && mem_be == 4'hF, "R2 wr/be", {mem_wr_en, mem_be}, 32'h1F);
            chk(mem_wdata == wd, "R2 wdata", mem_wdata, wd);
            shadow[ea[5:2]] = wd;
        end else if (op == OP_SB) begin
            chk(mem_wr_en && mem_be == 4'(1 << ln), "R3 wr/be", {mem_wr_en, mem_be}, {1'b1, 4'(1 << ln)});
            chk(mem_wdata[ln*8 +: 8] == wd[7:0], "R3 lane data", 32'(mem_wdata[ln*8 +: 8]), 32'(wd[7:0]));
            shadow[ea[5:2]][ln*8 +: 8] = wd[7:0];
        end else begin
            chk(mem_rd_en && !mem_wr_en, "R4 read strobe", {mem_rd_en, mem_wr_en}, 32'h2);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (!mis && !op[1]) begin
            word   = shadow[ea[5:2]];
            exp_ld = op[0] ? {{24{word[ln*8+7]}}, word[ln*8 +: 8]} : word;
            chk(ld_valid == 1'b1, "R4 ld_valid", 32'(ld_valid), 1);
            chk(ld_data == exp_ld, op[0] ? "R5 byte load" : "R4 word load", ld_data, exp_ld);
        end else begin
            chk(ld_valid == 1'b0, "R6 no result", 32'(ld_valid), 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]    = 32'h8041_C203 + 32'(i) * 32'h0404_0404;
            shadow[i] = 32'h8041_C203 + 32'(i) * 32'h0404_0404;
        end
        repeat (3) @(negedge clk);
        #1;
        // R9: reset state
        chk(!busy && !ld_valid && !mem_rd_en && !mem_wr_en, "R9 reset outputs",
            {busy, ld_valid, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            do_req(VECS[v].op, VECS[v].big, VECS[v].base, VECS[v].off, VECS[v].wdata, VECS[v].mis);

        // R8: request during ST_LOAD_WAIT is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = OP_LW; req_base = 32'h20; req_offset = 16'h0; big_endian = 1'b0;
        @(negedge clk);
        req_op = OP_SW; req_base = 32'h0; req_wdata = 32'h5555_5555;
        #1;
        chk(busy && !mem_wr_en && !mem_rd_en, "R8 busy ignores", {busy, mem_wr_en, mem_rd_en}, 32'h4);
        chk(ld_data == shadow[8], "R8 result during busy", ld_data, shadow[8]);
        @(negedge clk);
        req_valid = 1'b0;
        do_req(OP_LW, 1'b0, 32'h0, 16'h0, 32'h0, 1'b0);   // R8: word 0 untouched

        // R10: endianness flip while waiting
        @(negedge clk);
        req_valid = 1'b1; req_op = OP_LB; req_base = 32'h44; req_offset = 16'h0; big_endian = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; big_endian = 1'b0;
        #1;
        chk(ld_data == {{24{shadow[1][31]}}, shadow[1][31:24]}, "R10 held lane", ld_data,
            {{24{shadow[1][31]}}, shadow[1][31:24]});

        // R9: reset during ST_LOAD_WAIT
        @(negedge clk);
        req_valid = 1'b1; req_op = OP_LW; req_base = 32'h4; big_endian = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        #1;
        chk(!busy && !ld_valid, "R9 reset aborts load", {busy, ld_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        do_req(OP_LB, 1'b0, 32'h7, 16'h0, 32'h0, 1'b0);  // R5 R7 after reset

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule